// File: doc/BRIEF.md
# Framed CRC Generator and Checker

This block keeps a running CRC remainder over a stream of input beats and updates it once for each valid beat. A beat is either a single serial bit or a full byte. The width, the generator polynomial, the preset value and the expected receive residue are all parameters. The polynomial is stored with its top term left out. It only sets where the feedback taps sit; the register itself holds the remainder.

A frame-start strobe loads the preset value into the register. If a beat arrives in the same cycle as the strobe, that beat is folded in from the preset value. The old remainder is not used.

On the transmit side, the remainder appears on the output in the cycle after the last data beat. On the receive side, the data and its appended CRC are fed through the block. A registered flag then reports whether the remainder equals the expected residue.

Top module: `crc_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, `crcOut` equals the preset parameter `INIT_VAL` and `crcMatch` is 0.
- R2: In a cycle with neither `frameStart` nor `beatValid` high, `crcOut` and `crcMatch` keep their values at the next edge.
- R3: `frameStart` high with `beatValid` low loads `INIT_VAL` into the register at the next edge.
- R4: Serial mode (`byteMode` = 0) uses bit `dataIn[7]`. If the register MSB XOR that bit is 1, the next value is the register shifted left with a 0 entering bit 0, XORed with `GEN_POLY`. Otherwise it is only the shifted value. In `GEN_POLY`, bit i is the coefficient of x^i, and the x^N term is implied.
- R5: Byte mode (`byteMode` = 1) applies the R4 step eight times within one clock to `dataIn[7]` down to `dataIn[0]`, MSB first.
- R6: When `frameStart` and `beatValid` are both high, the beat is applied to `INIT_VAL` rather than to the current register.
- R7: `crcMatch` is registered. After any edge that updates the register, it is 1 exactly when the new `crcOut` equals `RESIDUE`. A frame followed by its own remainder, MSB byte first, leaves `crcMatch` at 1 when `RESIDUE` is 0.
- R8: With N=4, `GEN_POLY`=4'b0011 and `INIT_VAL`=0, the serial input 1101011011 leaves `crcOut` = 4'b1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frameStart | input | 1 | Preset strobe for a new frame |
| beatValid | input | 1 | Current beat carries data |
| byteMode | input | 1 | 1: eight-bit beat, 0: single bit on dataIn[7] |
| dataIn | input | 8 | Beat data, MSB processed first |
| crcOut | output | CRC_W | Running remainder |
| crcMatch | output | 1 | Registered flag: remainder equals RESIDUE |

## Verification
The bench builds two instances on shared stimulus. The first is a 4-bit instance with polynomial 0011, preset 0 and residue 1110. It reaches the textbook serial case directly. Because it has only 16 remainder values, random traffic drives `crcMatch` high often.

The second is a 16-bit instance with polynomial 0x1021, preset 0xFFFF and residue 0. It reaches an all-ones preset, a wide feedback pattern, and the append-and-check receive flow in byte mode.

// File: rtl/crc_engine_pkg.sv
package crc_engine_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;     // register takes a new value this edge
    logic preset;   // seed from the preset value instead of the register
    logic useBeat;  // fold the beat into the seed
    logic wide;     // eight-bit beat
  } crcCtrl_t;

  localparam int unsigned BEAT_BITS = 8;

endpackage

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
  parameter int unsigned CRC_W = 16,
  parameter logic [CRC_W-1:0] GEN_POLY = 16'h1021
) (
  input  logic [CRC_W-1:0] stateIn,
  input  logic             dataBit,
  output logic [CRC_W-1:0] stateOut
);
  logic feedback;
  logic [CRC_W-1:0] shifted;

  always_comb begin
    feedback = stateIn[CRC_W-1] ^ dataBit;
    shifted  = {stateIn[CRC_W-2:0], 1'b0};
    stateOut = feedback ? (shifted ^ GEN_POLY) : shifted;
  end
endmodule

// File: rtl/crc_engine_ctrl.sv
module crc_engine_ctrl
  import crc_engine_pkg::*;
(
  input  logic     frameStart,
  input  logic     beatValid,
  input  logic     byteMode,
  output crcCtrl_t ctrl
);
  always_comb begin
    ctrl.load    = frameStart | beatValid;
    ctrl.preset  = frameStart;
    ctrl.useBeat = beatValid;
    ctrl.wide    = byteMode;
  end
endmodule

// File: rtl/crc_engine_dp.sv
module crc_engine_dp
  import crc_engine_pkg::*;
#(
  parameter int unsigned CRC_W = 16,
  parameter logic [CRC_W-1:0] GEN_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT_VAL = 16'hFFFF,
  parameter logic [CRC_W-1:0] RESIDUE  = 16'h0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  crcCtrl_t             ctrl,
  input  logic [BEAT_BITS-1:0] dataIn,
  output logic [CRC_W-1:0]     crcOut,
  output logic                 crcMatch
);
  logic [CRC_W-1:0] crcReg;
  logic             matchReg;
  logic [CRC_W-1:0] seed;
  logic [CRC_W-1:0] nextVal;
  logic [CRC_W-1:0] chain [BEAT_BITS+1];

  assign seed     = ctrl.preset ? INIT_VAL : crcReg;
  assign chain[0] = seed;

  // Stage k consumes dataIn[7-k]; serial beats use only stage 0.
  for (genvar k = 0; k < BEAT_BITS; k++) begin : g_stage
    crc_bit_step #(.CRC_W(CRC_W), .GEN_POLY(GEN_POLY)) u_step (
      .stateIn (chain[k]),
      .dataBit (dataIn[BEAT_BITS-1-k]),
      .stateOut(chain[k+1])
    );
  end

  always_comb begin
    if (!ctrl.useBeat)  nextVal = seed;
    else if (ctrl.wide) nextVal = chain[BEAT_BITS];
    else                nextVal = chain[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crcReg   <= INIT_VAL;
      matchReg <= 1'b0;
    end else if (ctrl.load) begin
      crcReg   <= nextVal;
      matchReg <= (nextVal == RESIDUE);
    end
  end

  assign crcOut   = crcReg;
  assign crcMatch = matchReg;
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_engine_pkg::*;
#(
  parameter int unsigned CRC_W = 16,
  parameter logic [CRC_W-1:0] GEN_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT_VAL = 16'hFFFF,
  parameter logic [CRC_W-1:0] RESIDUE  = 16'h0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frameStart,
  input  logic             beatValid,
  input  logic             byteMode,
  input  logic [7:0]       dataIn,
  output logic [CRC_W-1:0] crcOut,
  output logic             crcMatch
);
  crcCtrl_t ctrl;

  crc_engine_ctrl u_ctrl (
    .frameStart(frameStart),
    .beatValid (beatValid),
    .byteMode  (byteMode),
    .ctrl      (ctrl)
  );

  crc_engine_dp #(
    .CRC_W(CRC_W), .GEN_POLY(GEN_POLY), .INIT_VAL(INIT_VAL), .RESIDUE(RESIDUE)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .dataIn  (dataIn),
    .crcOut  (crcOut),
    .crcMatch(crcMatch)
  );
endmodule

// File: rtl/crc_engine_checker.sv
module crc_engine_checker #(
  parameter int unsigned CRC_W = 16,
  parameter logic [CRC_W-1:0] GEN_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT_VAL = 16'hFFFF,
  parameter logic [CRC_W-1:0] RESIDUE  = 16'h0000
) (
  input logic             clk,
  input logic             rst,
  input logic             frameStart,
  input logic             beatValid,
  input logic             byteMode,
  input logic [7:0]       dataIn,
  input logic [CRC_W-1:0] crcOut,
  input logic             crcMatch
);
  function automatic logic [CRC_W-1:0] oneBit(logic [CRC_W-1:0] s, logic d);
    logic [CRC_W-1:0] t;
    t = s << 1;
    if (s[CRC_W-1] ^ d) t = t ^ GEN_POLY;
    return t;
  endfunction

  function automatic logic [CRC_W-1:0] oneByte(logic [CRC_W-1:0] s, logic [7:0] d);
    logic [CRC_W-1:0] t;
    t = s;
    for (int i = 7; i >= 0; i--) t = oneBit(t, d[i]);
    return t;
  endfunction

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!frameStart && !beatValid) |=> ($stable(crcOut) && $stable(crcMatch)));

  p_preset_r3: assert property (@(posedge clk) disable iff (rst)
    (frameStart && !beatValid) |=> (crcOut == INIT_VAL));

  p_serial_step_r4: assert property (@(posedge clk) disable iff (rst)
    (beatValid && !byteMode && !frameStart) |=>
      (crcOut == oneBit($past(crcOut), $past(dataIn[7]))));

  p_byte_step_r5: assert property (@(posedge clk) disable iff (rst)
    (beatValid && byteMode && !frameStart) |=>
      (crcOut == oneByte($past(crcOut), $past(dataIn))));

  p_preset_beat_r6: assert property (@(posedge clk) disable iff (rst)
    (beatValid && frameStart && byteMode) |=>
      (crcOut == oneByte(INIT_VAL, $past(dataIn))));

  p_match_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (frameStart || beatValid) |=> (crcMatch == (crcOut == RESIDUE)));

  p_reset_value_r1: assert property (@(posedge clk)
    rst |=> (crcOut == INIT_VAL && !crcMatch));
endmodule

bind crc_engine crc_engine_checker #(
  .CRC_W(CRC_W), .GEN_POLY(GEN_POLY), .INIT_VAL(INIT_VAL), .RESIDUE(RESIDUE)
) u_checker (
  .clk(clk), .rst(rst), .frameStart(frameStart), .beatValid(beatValid),
  .byteMode(byteMode), .dataIn(dataIn), .crcOut(crcOut), .crcMatch(crcMatch)
);

// File: tb/crc_engine_bench.sv
module crc_engine_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frameStart = 1'b0;
  logic beatValid = 1'b0;
  logic byteMode = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [3:0]  crcA;
  logic [15:0] crcB;
  logic matchA, matchB;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Reference state
  logic [31:0] refA, refB;
  logic refMatchA, refMatchB;

  localparam logic [3:0]  POLY_A = 4'h3, INIT_A = 4'h0, RES_A = 4'hE;
  localparam logic [15:0] POLY_B = 16'h1021, INIT_B = 16'hFFFF, RES_B = 16'h0000;

  always #10 clk = ~clk;

  crc_engine #(.CRC_W(4), .GEN_POLY(POLY_A), .INIT_VAL(INIT_A), .RESIDUE(RES_A)) u_crc_engine (
    .clk(clk), .rst(rst), .frameStart(frameStart), .beatValid(beatValid),
    .byteMode(byteMode), .dataIn(dataIn), .crcOut(crcA), .crcMatch(matchA));

  crc_engine #(.CRC_W(16), .GEN_POLY(POLY_B), .INIT_VAL(INIT_B), .RESIDUE(RES_B)) u_crc_engine_w16 (
    .clk(clk), .rst(rst), .frameStart(frameStart), .beatValid(beatValid),
    .byteMode(byteMode), .dataIn(dataIn), .crcOut(crcB), .crcMatch(matchB));

  function automatic logic [31:0] refBit(logic [31:0] s, logic d, int w, logic [31:0] poly);
    logic [31:0] mask, t;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    t = (s << 1) & mask;
    if (s[w-1] ^ d) t = t ^ poly;
    return t & mask;
  endfunction

  function automatic logic [31:0] refBeat(logic [31:0] s, logic [7:0] d, logic wide,
                                          int w, logic [31:0] poly);
    logic [31:0] t;
    t = s;
    if (wide) begin
      for (int i = 7; i >= 0; i--) t = refBit(t, d[i], w, poly);
    end else begin
      t = refBit(t, d[7], w, poly);
    end
    return t;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check({tag, " crcA"},   {28'd0, crcA},   refA);
    check({tag, " crcB"},   {16'd0, crcB},   refB);
    check({tag, " matchA"}, {31'd0, matchA}, {31'd0, refMatchA});
    check({tag, " matchB"}, {31'd0, matchB}, {31'd0, refMatchB});
  endtask

  // Drive at negedge, model the edge, sample at the following negedge.
  task automatic beat(logic sof, logic v, logic wide, logic [7:0] d, string tag);
    frameStart = sof; beatValid = v; byteMode = wide; dataIn = d;
    @(posedge clk);
    if (sof || v) begin
      logic [31:0] seedA, seedB;
      seedA = sof ? {28'd0, INIT_A} : refA;
      seedB = sof ? {16'd0, INIT_B} : refB;
      refA = v ? refBeat(seedA, d, wide, 4, {28'd0, POLY_A}) : seedA;
      refB = v ? refBeat(seedB, d, wide, 16, {16'd0, POLY_B}) : seedB;
      refMatchA = (refA == {28'd0, RES_A});
      refMatchB = (refB == {16'd0, RES_B});
    end
    @(negedge clk);
    frameStart = 1'b0; beatValid = 1'b0;
    checkAll(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] txCrc;
    logic [9:0] frameBits;
    void'($urandom(32'd2024));
    refA = {28'd0, INIT_A}; refB = {16'd0, INIT_B};
    refMatchA = 1'b0; refMatchB = 1'b0;

    // R1: reset values
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkAll("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    checkAll("R1 after reset");

    // R8/R6: textbook serial frame, first bit with frame start
    frameBits = 10'b1101011011;
    for (int i = 9; i >= 0; i--)
      beat(i == 9, 1'b1, 1'b0, {frameBits[i], 7'd0}, "R8 R6 R4 serial");
    check("R8 textbook remainder", {28'd0, crcA}, 32'hE);
    check("R7 residue hit A", {31'd0, matchA}, 32'd1);

    // R2: idle cycles hold
    beat(1'b0, 1'b0, 1'b1, 8'hA5, "R2 idle");
    beat(1'b0, 1'b0, 1'b0, 8'hFF, "R2 idle");

    // R3: preset alone
    beat(1'b1, 1'b0, 1'b1, 8'h3C, "R3 preset");
    check("R3 preset B", {16'd0, crcB}, 32'hFFFF);

    // R7: transmit then receive with appended remainder (byte mode)
    for (int f = 0; f < 20; f++) begin
      int len;
      len = 1 + int'($urandom_range(0, 11));
      beat(1'b1, 1'b1, 1'b1, 8'($urandom), "R6 R5 first byte");
      for (int k = 1; k < len; k++) beat(1'b0, 1'b1, 1'b1, 8'($urandom), "R5 byte");
      txCrc = crcB;
      check("R5 tx remainder", {16'd0, txCrc}, refB);
      beat(1'b0, 1'b1, 1'b1, txCrc[15:8], "R7 append hi");
      beat(1'b0, 1'b1, 1'b1, txCrc[7:0],  "R7 append lo");
      check("R7 residue zero B", {31'd0, matchB}, 32'd1);
    end

    // Random mix of all controls
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] r;
      r = 4'($urandom);
      beat(r[0] & r[1], r[2] | r[3], 4'($urandom) > 4'd7, 8'($urandom), "R2 R3 R4 R5 R6 R7 random");
    end

    // R1: reset again mid-frame
    beat(1'b0, 1'b1, 1'b1, 8'h5A, "R5 pre-reset");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    refA = {28'd0, INIT_A}; refB = {16'd0, INIT_B};
    refMatchA = 1'b0; refMatchB = 1'b0;
    @(negedge clk);
    checkAll("R1 re-reset");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule